// File: doc/BRIEF.md
# Four-Channel Peripheral Byte DMA Engine

This block moves single bytes between a synchronous RAM and four fixed peripheral data ports that serve a block cipher. Three of the ports consume bytes read from RAM: a key port, a data-block port and an XOR-operand port. The fourth port produces result bytes, and the block writes them into RAM. Each of the four channels has its own configuration. Software reaches that configuration through one shared register window. A channel-select register picks which channel the window addresses.

Each channel holds a code, a RAM base address, a byte count and a running offset. The code picks both the peripheral port and the direction. Each channel also has a wrap-mode bit and an interrupt-enable bit. A channel moves a byte when it is enabled, still has bytes left and its peripheral requests. The byte goes to or from address base plus offset, and the offset then advances by one. A channel without wrap stops when the offset reaches the size and raises its completion flag. A channel with wrap restarts at offset zero and raises no flag. Clearing a channel's enable bit pauses it, and because the offset is kept the transfer picks up where it left off.

Top module: `pdma_engine`

## Requirements
- R1: Register map on the 4-bit bus address: 0 channel select (bits 1:0), 1 enable (bit n = channel n), 2 completion flags, 3 channel config (bits 3:0 code, bit 7 interrupt enable), 4 channel mode (bit 0 wrap), 5/6 base low/high, 7/8 size low/high, 9/10 offset low/high. Addresses 3 to 10 read and write only the channel named by the select register.
- R2: Codes 5, 6 and 7 read RAM and deliver the byte on `pout_data` with a one-cycle strobe on `key_vld`, `blk_vld` or `xor_vld` respectively. Code 8 writes `res_data` into RAM, with `res_take` asserted in the same cycle as `ram_we`. Any other code never moves data.
- R3: The RAM address of each transfer is base plus offset, and the offset grows by one after each byte.
- R4: Without wrap, the byte that brings the offset to the size sets that channel's completion flag. The channel then moves no further bytes, and its enable bit stays set.
- R5: With wrap, the byte that brings the offset to the size resets the offset to zero, and the completion flag stays clear.
- R6: Writing the flag register clears every flag whose written bit is 0. Flags whose written bit is 1 are left unchanged.
- R7: `irq` is high exactly when some channel has both its completion flag and its interrupt-enable bit set.
- R8: When several channels could move a byte in the same cycle, the lowest-numbered channel goes first.
- R9: A RAM access is never issued in two consecutive cycles. The read strobe for a byte appears in the cycle right after its RAM read.
- R10: Clearing a channel's enable bit stops it with its offset kept. Setting the bit again resumes the transfer from that offset.
- R11: After reset, every register reads zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register bus address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ram_addr | output | 16 | RAM byte address |
| ram_re | output | 1 | RAM read, data valid next cycle |
| ram_we | output | 1 | RAM write |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |
| key_req | input | 1 | Key port wants a byte |
| key_vld | output | 1 | Key byte strobe |
| blk_req | input | 1 | Data-block port wants a byte |
| blk_vld | output | 1 | Data-block byte strobe |
| xor_req | input | 1 | XOR-operand port wants a byte |
| xor_vld | output | 1 | XOR-operand byte strobe |
| pout_data | output | 8 | Byte delivered to the peripheral ports |
| res_req | input | 1 | Result port has a byte |
| res_data | input | 8 | Result byte |
| res_take | output | 1 | Result byte consumed |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
The hardest case to reach is the pause and resume of a channel partway through its transfer. It needs the enable bit cleared between bytes while the peripheral keeps requesting. Then the block must show that no byte moved, that the offset it reads back is unchanged, and that after re-enabling the next write lands at the continued address. The bench builds this with request counters on each peripheral: it grants a result channel exactly three bytes, clears the enable bit, raises two more requests that must stay unserved, and then re-enables the channel. The scoreboard expects the remaining writes at base plus three onward. Priority is checked by releasing two channels in the same cycle and expecting all of the lower channel's bytes first.

// File: rtl/pdma_engine.sv
module pdma_engine #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int RAW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RAW-1:0] reg_addr,
  input  logic           reg_we,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic [AW-1:0]  ram_addr,
  output logic           ram_re,
  output logic           ram_we,
  output logic [DW-1:0]  ram_wdata,
  input  logic [DW-1:0]  ram_rdata,
  input  logic           key_req,
  output logic           key_vld,
  input  logic           blk_req,
  output logic           blk_vld,
  input  logic           xor_req,
  output logic           xor_vld,
  output logic [DW-1:0]  pout_data,
  input  logic           res_req,
  input  logic [DW-1:0]  res_data,
  output logic           res_take,
  output logic           irq
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [3:0] C_KEY = 4'h5, C_BLK = 4'h6, C_XOR = 4'h7, C_RES = 4'h8;
  localparam logic [RAW-1:0] A_SEL = 0, A_EN = 1, A_FLG = 2, A_CFG = 3, A_MODE = 4,
    A_BL = 5, A_BH = 6, A_SL = 7, A_SH = 8, A_OL = 9, A_OH = 10;

  logic [CW-1:0]  sel;
  logic [NCH-1:0] en, flg, ie, wrap, preq, elig, fset;
  logic [3:0]     code [NCH];
  logic [AW-1:0]  base [NCH];
  logic [AW-1:0]  size [NCH];
  logic [AW-1:0]  off  [NCH];
  logic           busy, hit, issue, is_wr;
  logic [CW-1:0]  cur, gnt;
  logic [3:0]     cur_code;
  logic [AW-1:0]  nxt;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      case (code[i])
        C_KEY:   preq[i] = key_req;
        C_BLK:   preq[i] = blk_req;
        C_XOR:   preq[i] = xor_req;
        C_RES:   preq[i] = res_req;
        default: preq[i] = 1'b0;
      endcase
      elig[i] = en[i] && (off[i] < size[i]) && preq[i];
    end
  end

  always_comb begin
    gnt = '0;
    hit = 1'b0;
    for (int i = NCH - 1; i >= 0; i--)
      if (elig[i]) begin
        gnt = CW'(i);
        hit = 1'b1;
      end
  end

  assign issue     = !busy && hit;
  assign is_wr     = code[gnt] == C_RES;
  assign ram_addr  = base[gnt] + off[gnt];
  assign ram_re    = issue && !is_wr;
  assign ram_we    = issue && is_wr;
  assign ram_wdata = res_data;
  assign res_take  = ram_we;
  assign pout_data = ram_rdata;
  assign key_vld   = busy && cur_code == C_KEY;
  assign blk_vld   = busy && cur_code == C_BLK;
  assign xor_vld   = busy && cur_code == C_XOR;
  assign irq       = |(flg & ie);
  assign nxt       = off[cur] + AW'(1);

  always_comb begin
    fset = '0;
    if (busy && nxt == size[cur] && !wrap[cur]) fset[cur] = 1'b1;
  end

  always_comb begin
    case (reg_addr)
      A_SEL:   reg_rdata = DW'(sel);
      A_EN:    reg_rdata = DW'(en);
      A_FLG:   reg_rdata = DW'(flg);
      A_CFG:   reg_rdata = {ie[sel], 3'b000, code[sel]};
      A_MODE:  reg_rdata = DW'(wrap[sel]);
      A_BL:    reg_rdata = base[sel][DW-1:0];
      A_BH:    reg_rdata = base[sel][AW-1:DW];
      A_SL:    reg_rdata = size[sel][DW-1:0];
      A_SH:    reg_rdata = size[sel][AW-1:DW];
      A_OL:    reg_rdata = off[sel][DW-1:0];
      A_OH:    reg_rdata = off[sel][AW-1:DW];
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel <= '0; en <= '0; flg <= '0; ie <= '0; wrap <= '0;
      busy <= 1'b0; cur <= '0; cur_code <= '0;
      for (int i = 0; i < NCH; i++) begin
        code[i] <= '0; base[i] <= '0; size[i] <= '0; off[i] <= '0;
      end
    end else begin
      busy <= issue;
      if (issue) begin
        cur      <= gnt;
        cur_code <= code[gnt];
      end
      if (busy) off[cur] <= (nxt == size[cur] && wrap[cur]) ? '0 : nxt;
      flg <= ((reg_we && reg_addr == A_FLG) ? (flg & reg_wdata[NCH-1:0]) : flg) | fset;
      if (reg_we)
        case (reg_addr)
          A_SEL:  sel <= reg_wdata[CW-1:0];
          A_EN:   en <= reg_wdata[NCH-1:0];
          A_CFG:  begin code[sel] <= reg_wdata[3:0]; ie[sel] <= reg_wdata[7]; end
          A_MODE: wrap[sel] <= reg_wdata[0];
          A_BL:   base[sel][DW-1:0]  <= reg_wdata;
          A_BH:   base[sel][AW-1:DW] <= reg_wdata[AW-DW-1:0];
          A_SL:   size[sel][DW-1:0]  <= reg_wdata;
          A_SH:   size[sel][AW-1:DW] <= reg_wdata[AW-DW-1:0];
          A_OL:   off[sel][DW-1:0]   <= reg_wdata;
          A_OH:   off[sel][AW-1:DW]  <= reg_wdata[AW-DW-1:0];
          default: ;
        endcase
    end
  end

  // R9
  ram_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_re || ram_we) |=> !(ram_re || ram_we));
  // R2
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_vld || blk_vld || xor_vld) |-> $past(ram_re));
  // R4
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flg & ~$past(flg)) != '0) |-> $past(busy));
  // R5
  wrap_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flg & ~$past(flg)) != '0) |-> !$past(wrap[cur]));
  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flg != '0));
endmodule

// File: tb/tb_pdma_engine.sv
module tb_pdma_engine;
  logic clk = 0, rst_n = 0;
  logic [3:0] reg_addr = 0;
  logic reg_we = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [15:0] ram_addr;
  logic ram_re, ram_we;
  logic [7:0] ram_wdata, ram_rdata = 0, pout_data, res_data;
  logic key_vld, blk_vld, xor_vld, res_take, irq;
  logic key_req, blk_req, xor_req, res_req;

  typedef struct {int port; int addr; int data;} item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  int key_given = 0, blk_given = 0, xor_given = 0, res_given = 0;
  int key_taken = 0, blk_taken = 0, xor_taken = 0, res_taken = 0;
  logic [7:0] mem [256];
  logic prev_re = 0, prev_issue = 0;

  always #2 clk = ~clk;

  pdma_engine dut (.*);

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  assign key_req  = key_given != key_taken;
  assign blk_req  = blk_given != blk_taken;
  assign xor_req  = xor_given != xor_taken;
  assign res_req  = res_given != res_taken;
  assign res_data = 8'(8'h90 + res_taken);

  initial for (int i = 0; i < 256; i++) mem[i] = pat(i);

  always @(posedge clk) begin
    if (ram_we) mem[ram_addr[7:0]] <= ram_wdata;
    if (ram_re) ram_rdata <= mem[ram_addr[7:0]];
    if (key_vld) key_taken <= key_taken + 1;
    if (blk_vld) blk_taken <= blk_taken + 1;
    if (xor_vld) xor_taken <= xor_taken + 1;
    if (res_take) res_taken <= res_taken + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ev(input int port, input int addr, input int data);
    item_t e;
    if (q.size() == 0) begin
      checks++; errors++;
      $display("FAIL R4: actual=unexpected transfer port %0d expected=none", port);
    end else begin
      e = q.pop_front();
      chk("R8 port order", port, e.port);
      chk("R2 data", data, e.data);
      if (port == 8) chk("R3 address", addr, e.addr);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (key_vld) ev(5, -1, pout_data);
      if (blk_vld) ev(6, -1, pout_data);
      if (xor_vld) ev(7, -1, pout_data);
      if (ram_we) ev(8, ram_addr, ram_wdata);
      if (prev_re) chk("R9 strobe follows read", int'(key_vld | blk_vld | xor_vld), 1);
      if (ram_re || ram_we) chk("R9 access spacing", int'(prev_issue), 0);
      prev_re = ram_re;
      prev_issue = ram_re | ram_we;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_addr = 4'(a); reg_wdata = 8'(d); reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    @(negedge clk); reg_addr = 4'(a); #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic setup(input int ch, input int cfg, input int mode, input int b, input int sz);
    wr(0, ch); wr(3, cfg); wr(4, mode);
    wr(5, b & 255); wr(6, b >> 8); wr(7, sz & 255); wr(8, sz >> 8);
    wr(9, 0); wr(10, 0);
  endtask

  task automatic give_rd(input int port, input int b, input int sz, input int start, input int n);
    for (int k = 0; k < n; k++) begin
      item_t e;
      e.port = port; e.addr = -1; e.data = pat(b + (start + k) % sz);
      q.push_back(e);
    end
  endtask

  task automatic drain();
    for (int t = 0; t < 400 && q.size() != 0; t++) @(negedge clk);
    chk("R2 all items seen", q.size(), 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    rd(0, 0, "R11 sel"); rd(1, 0, "R11 enable"); rd(2, 0, "R11 flags");
    rd(5, 0, "R11 base"); rd(7, 0, "R11 size");
    chk("R11 irq", irq, 0);
    // R1 window isolation
    wr(0, 1); wr(5, 8'h34);
    wr(0, 0); rd(5, 0, "R1 other channel untouched");
    wr(0, 1); rd(5, 8'h34, "R1 selected channel");
    // R8 two channels ready together
    setup(0, 8'h85, 0, 16'h0010, 4);
    setup(1, 8'h06, 0, 16'h0040, 3);
    wr(1, 3);
    give_rd(5, 16'h10, 4, 0, 4);
    give_rd(6, 16'h40, 3, 0, 3);
    @(negedge clk); key_given += 4; blk_given += 3;
    drain();
    rd(2, 3, "R4 flags set");
    rd(1, 3, "R4 enable kept");
    chk("R7 irq with ie", irq, 1);
    wr(0, 1); rd(9, 3, "R3 offset advanced");
    // R6 flag clear
    wr(2, 8'hFE); rd(2, 2, "R6 clear by zero");
    chk("R7 irq without ie", irq, 0);
    // R4 stopped channel ignores requests
    @(negedge clk); key_given += 1;
    repeat (10) @(negedge clk);
    chk("R4 stopped channel idle", key_given - key_taken, 1);
    key_given = key_taken;
    // R5 wrap
    setup(2, 8'h07, 1, 16'h0080, 2);
    wr(1, 7);
    give_rd(7, 16'h80, 2, 0, 5);
    @(negedge clk); xor_given += 5;
    drain();
    rd(2, 2, "R5 no flag on wrap");
    wr(0, 2); rd(9, 1, "R5 offset wrapped");
    // R10 pause and resume
    setup(3, 8'h08, 0, 16'h00C0, 6);
    wr(1, 15);
    for (int k = 0; k < 3; k++) q.push_back('{8, 16'hC0 + k, 8'h90 + k});
    @(negedge clk); res_given += 3;
    drain();
    wr(1, 7);
    @(negedge clk); res_given += 2;
    repeat (10) @(negedge clk);
    chk("R10 paused channel idle", res_given - res_taken, 2);
    wr(0, 3); rd(9, 3, "R10 offset frozen");
    for (int k = 3; k < 6; k++) q.push_back('{8, 16'hC0 + k, 8'h90 + k});
    wr(1, 15);
    @(negedge clk); res_given += 1;
    drain();
    rd(2, 10, "R4 result channel flag");
    chk("R7 irq masked", irq, 0);
    for (int k = 0; k < 6; k++) chk("R2 ram written", mem[8'hC0 + k], 8'h90 + k);
    finish_run();
  end
endmodule